// File: doc/BRIEF.md
# Host Command and Status Interface

This block is the processor-facing front end of a dot-matrix display controller. A host drives byte-wide transfers with a select, a write strobe, a read strobe and a command/data selector. Parameter bytes always go first and the opcode byte last. The block keeps the two most recent parameter bytes and decodes each opcode byte when it arrives. It then loads its address, cursor, character-generator base and window registers, or it starts an access to display memory. That access leaves through a single-request port toward a display-RAM arbiter.

Memory accesses come in three kinds: a single write, a single read, and a read-modify-write that sets or clears one bit of the byte at the address pointer. A streaming mode lets the host move a run of bytes with no opcode between them. In this mode the pointer advances after every byte, and the status word reports readiness through different bits. A status read returns that word at any time, without side effects. Consecutive accepted bytes must be spaced by at least one machine cycle.

Top module: `hci_host_if`

## Requirements
- R1: A status read (command/data selector high) returns a byte with these bits: bit 0 = command acceptable, bit 1 = data transfer possible, bit 2 = streaming read ready, bit 3 = streaming write ready, bit 4 = 0, bit 5 = 1 (running), bit 6 = error, bit 7 = the `scan_blink` input. When idle after reset this byte is 23h, or A3h with `scan_blink` high.
- R2: Data-phase writes outside streaming mode stage parameter bytes. When more than two arrive, only the last two are kept: the older one is operand 1 and the newer one is operand 2. Every accepted or rejected opcode empties the stage.
- R3: Opcode 24h loads the 16-bit address pointer with operand 1 as the low byte and operand 2 as the high byte.
- R4: Opcode 21h loads cursor X from operand 1 bits 6:0 and cursor Y from operand 2 bits 4:0. Opcode 22h loads the 5-bit character-generator base from operand 1 bits 4:0.
- R5: Opcodes 40h, 41h, 42h and 43h load, in that order: the text base address (16 bits, operand 1 low), the text row width (operand 1), the graphic base address and the graphic row width.
- R6: Opcodes C0h, C2h and C4h request one memory write of the newest parameter byte at the pointer. Afterwards the pointer is incremented, decremented or left unchanged, respectively. A request holds its address and data until acknowledged.
- R7: Opcodes C1h, C3h and C5h request one memory read at the pointer and step the pointer in the same three ways. A data-phase read then returns the byte that was fetched.
- R8: An opcode with bits 7:4 = 1111b reads the byte at the pointer. It then writes that byte back with bit [2:0] set (bit 3 = 1) or cleared (bit 3 = 0), leaving the pointer unchanged. Status bits 0 and 1 stay low until both requests finish.
- R9: Opcode B0h enters streaming write: each data-phase write is stored at the pointer, which then increments. Opcode B1h enters streaming read: it prefetches at the pointer, and each data-phase read returns the held byte and fetches the next one. In streaming mode, status bits 0 and 1 read 0. Bit 3 (write mode) or bit 2 (read mode) reads 1 when the block is ready.
- R10: In streaming mode every opcode except B2h is rejected and sets the error bit. B2h leaves streaming mode.
- R11: A write, or a streaming data-phase read, that arrives fewer than CYCLE_CLKS clocks after the previous accepted byte is dropped.
- R12: An unknown opcode, or an opcode that arrives with fewer staged operands than it needs, has no effect and sets the error bit. The next accepted opcode clears the error bit. Opcodes 21h, 22h, 24h and 40h–43h need two operands; C0h, C2h and C4h need one.
- R13: Reset clears the address pointer, streaming mode and the operand stage.
- R14: Opcodes 8xh load the 4-bit mix-mode field from bits 3:0. Opcodes 9xh load the 4-bit view field from bits 3:0. Opcodes A0h–A7h load the 3-bit cursor-height field from bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host select; gates both strobes |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe |
| host_cmd | input | 1 | High: opcode write / status read; low: data phase |
| host_din | input | 8 | Byte from host |
| host_dout | output | 8 | Status or read byte to host |
| host_dout_en | output | 1 | Drive enable for the host bus |
| scan_blink | input | 1 | Blink phase from the scan logic, shown in status bit 7 |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Arbiter completes the request this cycle |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| cfg_text_base | output | 16 | Text base address |
| cfg_text_cols | output | 8 | Text row width |
| cfg_gfx_base | output | 16 | Graphic base address |
| cfg_gfx_cols | output | 8 | Graphic row width |
| cfg_cur_x | output | 7 | Cursor column |
| cfg_cur_y | output | 5 | Cursor row |
| cfg_cg_base | output | 5 | Character-generator base |
| cfg_mix | output | 4 | Mix-mode field |
| cfg_view | output | 4 | View field |
| cfg_cur_rows | output | 3 | Cursor height field |

## Verification
A wrong pointer does not show up until the next memory request. That request then carries an unexpected address, so the scoreboard compares every request against its expected address, direction and data as soon as the arbiter sees it. A stale streaming or busy state is visible in the very next status read, because the four readiness bits change pattern. Likewise, a mis-staged operand or a pacing error shows up in the address of the write that follows, or in the error bit.

// File: rtl/hci_pkg.sv
package hci_pkg;

    localparam int DW  = 8;
    localparam int AW  = 16;
    localparam int CXW = 7;
    localparam int CYW = 5;
    localparam int OFW = 5;

    typedef enum logic [1:0] {AM_OFF, AM_WRITE, AM_READ} auto_e;

    typedef enum logic [3:0] {
        K_BAD, K_CURSOR, K_OFFSET, K_PTR, K_CTRL, K_MIX, K_VIEW, K_CROWS,
        K_AUTO_W, K_AUTO_R, K_AUTO_END, K_WR, K_RD, K_BIT
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [3:0] arg;
    } cmd_t;

    typedef enum logic [1:0] {J_WR, J_RD, J_RMW} jop_e;

    typedef struct packed {
        jop_e          op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [2:0]    bsel;
        logic          bset;
    } job_t;

    typedef struct packed {
        logic blink;
        logic err;
        logic run;
        logic rsv;
        logic stream_wr_rdy;
        logic stream_rd_rdy;
        logic data_ok;
        logic cmd_ok;
    } status_t;

    function automatic cmd_t decode_op(input logic [7:0] c);
        cmd_t r;
        r.kind = K_BAD;
        r.arg  = c[3:0];
        casez (c)
            8'h21:         r.kind = K_CURSOR;
            8'h22:         r.kind = K_OFFSET;
            8'h24:         r.kind = K_PTR;
            8'b0100_00??:  r.kind = K_CTRL;
            8'b1000_????:  r.kind = K_MIX;
            8'b1001_????:  r.kind = K_VIEW;
            8'b1010_0???:  r.kind = K_CROWS;
            8'hB0:         r.kind = K_AUTO_W;
            8'hB1:         r.kind = K_AUTO_R;
            8'hB2:         r.kind = K_AUTO_END;
            8'b1100_0???: begin
                if (c[2:1] != 2'b11) r.kind = c[0] ? K_RD : K_WR;
            end
            8'b1111_????:  r.kind = K_BIT;
            default:       r.kind = K_BAD;
        endcase
        return r;
    endfunction

    function automatic logic [1:0] ops_needed(input kind_e k);
        case (k)
            K_CURSOR, K_OFFSET, K_PTR, K_CTRL: return 2'd2;
            K_WR:                              return 2'd1;
            default:                           return 2'd0;
        endcase
    endfunction

    function automatic logic [DW-1:0] bit_apply(input logic [DW-1:0] b,
                                                input logic [2:0] idx,
                                                input logic s);
        logic [DW-1:0] r;
        r = b;
        r[idx] = s;
        return r;
    endfunction

endpackage

// File: rtl/hci_operand_stage.sv
module hci_operand_stage
    import hci_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push,
    input  logic                           clear,
    input  logic [DW-1:0]                  din,
    output logic [DW-1:0]                  newest,
    output logic [DW-1:0]                  older,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] slot_q [DEPTH];
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (push) begin
            slot_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) slot_q[i] <= slot_q[i-1];
            if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign newest = slot_q[0];
    assign older  = slot_q[1];
    assign count  = cnt_q;

    // R2: the stage never claims more bytes than it holds
    assert_stage_cap_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R2: an opcode always leaves the stage empty
    assert_stage_clear_R2: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/hci_cmd_decode.sv
module hci_cmd_decode
    import hci_pkg::*;
(
    input  logic [DW-1:0] opcode,
    output cmd_t          cmd,
    output logic [1:0]    need
);
    always_comb begin
        cmd  = decode_op(opcode);
        need = ops_needed(cmd.kind);
    end
endmodule

// File: rtl/hci_mem_seq.sv
module hci_mem_seq
    import hci_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  job_t          job,
    output logic          busy,
    output logic [DW-1:0] rd_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    typedef enum logic [1:0] {S_IDLE, S_REQ, S_WB} st_e;

    st_e           st_q;
    job_t          job_q;
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            job_q <= '0;
            rd_q  <= '0;
        end else begin
            case (st_q)
                S_IDLE: if (start) begin
                    job_q <= job;
                    st_q  <= S_REQ;
                end
                S_REQ: if (mem_ack) begin
                    case (job_q.op)
                        J_WR: st_q <= S_IDLE;
                        J_RD: begin
                            rd_q <= mem_rdata;
                            st_q <= S_IDLE;
                        end
                        default: begin
                            job_q.wdata <= bit_apply(mem_rdata, job_q.bsel, job_q.bset);
                            st_q        <= S_WB;
                        end
                    endcase
                end
                S_WB: if (mem_ack) st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign busy      = (st_q != S_IDLE);
    assign mem_req   = (st_q != S_IDLE);
    assign mem_we    = (st_q == S_WB) || (st_q == S_REQ && job_q.op == J_WR);
    assign mem_addr  = job_q.addr;
    assign mem_wdata = job_q.wdata;
    assign rd_data   = rd_q;

    // R6: a pending request keeps address, direction and data until acknowledged
    assert_req_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R8: the read half of a bit update is followed at once by a write to the same byte
    assert_rmw_pair_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_REQ && job_q.op == J_RMW && mem_ack)
            |=> (mem_req && mem_we && $stable(mem_addr)));

    // R8: the front end never launches a job while one is in flight
    assert_start_idle_R8: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

endmodule

// File: rtl/hci_host_if.sv
module hci_host_if
    import hci_pkg::*;
#(
    parameter int CYCLE_CLKS = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           host_sel,
    input  logic           host_wr,
    input  logic           host_rd,
    input  logic           host_cmd,
    input  logic [7:0]     host_din,
    output logic [7:0]     host_dout,
    output logic           host_dout_en,
    input  logic           scan_blink,
    output logic           mem_req,
    output logic           mem_we,
    output logic [15:0]    mem_addr,
    output logic [7:0]     mem_wdata,
    input  logic           mem_ack,
    input  logic [7:0]     mem_rdata,
    output logic [15:0]    cfg_text_base,
    output logic [7:0]     cfg_text_cols,
    output logic [15:0]    cfg_gfx_base,
    output logic [7:0]     cfg_gfx_cols,
    output logic [6:0]     cfg_cur_x,
    output logic [4:0]     cfg_cur_y,
    output logic [4:0]     cfg_cg_base,
    output logic [3:0]     cfg_mix,
    output logic [3:0]     cfg_view,
    output logic [2:0]     cfg_cur_rows
);
    localparam int GW = (CYCLE_CLKS > 2) ? $clog2(CYCLE_CLKS) : 1;
    localparam logic [GW-1:0] GAP_LOAD = GW'(CYCLE_CLKS - 1);

    logic [GW-1:0] gap_q;
    auto_e         auto_q;
    logic          err_q;
    logic [AW-1:0] ptr_q, ptr_nx;

    logic [AW-1:0] text_base_q, gfx_base_q;
    logic [DW-1:0] text_cols_q, gfx_cols_q;
    logic [CXW-1:0] cur_x_q;
    logic [CYW-1:0] cur_y_q;
    logic [OFW-1:0] cg_base_q;
    logic [3:0]    mix_q, view_q;
    logic [2:0]    crows_q;

    logic          seq_busy;
    logic [DW-1:0] seq_rdata;
    logic          job_go;
    job_t          job;

    logic          free, cmd_wr, dat_wr, dat_rd, acc_byte, cmd_ok, exec;
    logic [DW-1:0] op_new, op_old;
    logic [1:0]    op_cnt, need;
    cmd_t          dec;
    status_t       st;

    assign free     = (gap_q == '0) && !seq_busy;
    assign cmd_wr   = host_sel && host_wr && host_cmd && free;
    assign dat_wr   = host_sel && host_wr && !host_cmd && free;
    assign dat_rd   = host_sel && host_rd && !host_cmd && free && (auto_q == AM_READ);
    assign acc_byte = cmd_wr || dat_wr || dat_rd;

    hci_operand_stage #(.DEPTH(2)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .push   (dat_wr && auto_q == AM_OFF),
        .clear  (cmd_wr),
        .din    (host_din),
        .newest (op_new),
        .older  (op_old),
        .count  (op_cnt)
    );

    hci_cmd_decode u_dec (
        .opcode (host_din),
        .cmd    (dec),
        .need   (need)
    );

    assign cmd_ok = (dec.kind != K_BAD) && (op_cnt >= need)
                    && (auto_q == AM_OFF || dec.kind == K_AUTO_END);
    assign exec   = cmd_wr && cmd_ok;

    always_comb begin
        job_go    = 1'b0;
        job       = '0;
        job.op    = J_RD;
        job.addr  = ptr_q;
        job.wdata = op_new;
        job.bsel  = dec.arg[2:0];
        job.bset  = dec.arg[3];
        ptr_nx    = ptr_q;
        if (exec) begin
            case (dec.kind)
                K_PTR: ptr_nx = {op_new, op_old};
                K_AUTO_R: begin
                    job_go = 1'b1;
                    ptr_nx = ptr_q + 1'b1;
                end
                K_WR, K_RD: begin
                    job_go = 1'b1;
                    job.op = (dec.kind == K_WR) ? J_WR : J_RD;
                    case (dec.arg[2:1])
                        2'b00:   ptr_nx = ptr_q + 1'b1;
                        2'b01:   ptr_nx = ptr_q - 1'b1;
                        default: ptr_nx = ptr_q;
                    endcase
                end
                K_BIT: begin
                    job_go = 1'b1;
                    job.op = J_RMW;
                end
                default: ;
            endcase
        end else if (dat_wr && auto_q == AM_WRITE) begin
            job_go    = 1'b1;
            job.op    = J_WR;
            job.wdata = host_din;
            ptr_nx    = ptr_q + 1'b1;
        end else if (dat_rd) begin
            job_go = 1'b1;
            ptr_nx = ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q       <= '0;
            auto_q      <= AM_OFF;
            err_q       <= 1'b0;
            ptr_q       <= '0;
            text_base_q <= '0;
            gfx_base_q  <= '0;
            text_cols_q <= '0;
            gfx_cols_q  <= '0;
            cur_x_q     <= '0;
            cur_y_q     <= '0;
            cg_base_q   <= '0;
            mix_q       <= '0;
            view_q      <= '0;
            crows_q     <= '0;
        end else begin
            if (acc_byte)          gap_q <= GAP_LOAD;
            else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
            ptr_q <= ptr_nx;
            if (cmd_wr) err_q <= !cmd_ok;
            if (exec) begin
                case (dec.kind)
                    K_CURSOR: begin
                        cur_x_q <= op_old[CXW-1:0];
                        cur_y_q <= op_new[CYW-1:0];
                    end
                    K_OFFSET: cg_base_q <= op_old[OFW-1:0];
                    K_CTRL: begin
                        case (dec.arg[1:0])
                            2'd0:    text_base_q <= {op_new, op_old};
                            2'd1:    text_cols_q <= op_old;
                            2'd2:    gfx_base_q  <= {op_new, op_old};
                            default: gfx_cols_q  <= op_old;
                        endcase
                    end
                    K_MIX:      mix_q   <= dec.arg;
                    K_VIEW:     view_q  <= dec.arg;
                    K_CROWS:    crows_q <= dec.arg[2:0];
                    K_AUTO_W:   auto_q  <= AM_WRITE;
                    K_AUTO_R:   auto_q  <= AM_READ;
                    K_AUTO_END: auto_q  <= AM_OFF;
                    default: ;
                endcase
            end
        end
    end

    hci_mem_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (job_go),
        .job       (job),
        .busy      (seq_busy),
        .rd_data   (seq_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    always_comb begin
        st               = '0;
        st.cmd_ok        = free && (auto_q == AM_OFF);
        st.data_ok       = free && (auto_q == AM_OFF);
        st.stream_rd_rdy = free && (auto_q == AM_READ);
        st.stream_wr_rdy = free && (auto_q == AM_WRITE);
        st.run           = 1'b1;
        st.err           = err_q;
        st.blink         = scan_blink;
    end

    assign host_dout    = host_cmd ? st : seq_rdata;
    assign host_dout_en = host_sel && host_rd;

    assign cfg_text_base = text_base_q;
    assign cfg_text_cols = text_cols_q;
    assign cfg_gfx_base  = gfx_base_q;
    assign cfg_gfx_cols  = gfx_cols_q;
    assign cfg_cur_x     = cur_x_q;
    assign cfg_cur_y     = cur_y_q;
    assign cfg_cg_base   = cg_base_q;
    assign cfg_mix       = mix_q;
    assign cfg_view      = view_q;
    assign cfg_cur_rows  = crows_q;

    // R8: while memory work is in flight the host is told to wait
    assert_busy_status_R8: assert property (@(posedge clk) disable iff (rst)
        seq_busy |-> (st.cmd_ok == 1'b0 && st.data_ok == 1'b0));

    // R9: streaming mode never advertises the single-transfer bits
    assert_auto_status_R9: assert property (@(posedge clk) disable iff (rst)
        (auto_q != AM_OFF) |-> (st.cmd_ok == 1'b0 && st.data_ok == 1'b0));

    // R10: a foreign opcode in streaming mode changes nothing but the error bit
    assert_auto_lock_R10: assert property (@(posedge clk) disable iff (rst)
        (auto_q != AM_OFF && cmd_wr && dec.kind != K_AUTO_END)
            |=> (err_q && $stable(auto_q) && $stable(ptr_q)));

    // R11: a strobe inside the pacing window leaves the pointer untouched
    assert_pace_drop_R11: assert property (@(posedge clk) disable iff (rst)
        (host_sel && host_wr && gap_q != '0) |=> $stable(ptr_q));

    // R12: an accepted opcode clears the error bit
    assert_err_clear_R12: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_ok) |=> !err_q);

endmodule

// File: tb/hci_host_if_test.sv
module hci_host_if_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0, host_cmd = 1'b0;
    logic [7:0]  host_din = 8'h00;
    logic [7:0]  host_dout;
    logic        host_dout_en;
    logic        scan_blink = 1'b0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] cfg_text_base, cfg_gfx_base;
    logic [7:0]  cfg_text_cols, cfg_gfx_cols;
    logic [6:0]  cfg_cur_x;
    logic [4:0]  cfg_cur_y, cfg_cg_base;
    logic [3:0]  cfg_mix, cfg_view;
    logic [2:0]  cfg_cur_rows;

    int checks = 0;
    int failures = 0;
    int resp_delay = 2;

    typedef struct {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  data;
        string       tag;
    } mexp_t;

    mexp_t      exp_q[$];
    logic [7:0] ram [256];

    always #4 clk = ~clk;

    hci_host_if uut (
        .clk(clk), .rst(rst),
        .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd), .host_cmd(host_cmd),
        .host_din(host_din), .host_dout(host_dout), .host_dout_en(host_dout_en),
        .scan_blink(scan_blink),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .cfg_text_base(cfg_text_base), .cfg_text_cols(cfg_text_cols),
        .cfg_gfx_base(cfg_gfx_base), .cfg_gfx_cols(cfg_gfx_cols),
        .cfg_cur_x(cfg_cur_x), .cfg_cur_y(cfg_cur_y), .cfg_cg_base(cfg_cg_base),
        .cfg_mix(cfg_mix), .cfg_view(cfg_view), .cfg_cur_rows(cfg_cur_rows)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_mem(input logic we, input logic [15:0] a, input logic [7:0] d,
                              input string tag);
        mexp_t e;
        e.we = we; e.addr = a; e.data = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic host_write(input logic is_cmd, input logic [7:0] b, input int gap);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_cmd = is_cmd; host_din = b;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic host_read(input logic is_cmd, output logic [7:0] v);
        @(negedge clk);
        host_sel = 1'b1; host_rd = 1'b1; host_cmd = is_cmd;
        #1 v = host_dout;
        @(negedge clk);
        host_sel = 1'b0; host_rd = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // scoreboard monitor: plays the arbiter and compares each request
    initial begin
        mexp_t e;
        forever begin
            @(negedge clk);
            if (mem_req && !rst) begin
                if (resp_delay > 1) repeat (resp_delay - 1) @(negedge clk);
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL R6 unexpected request actual=%h/%b expected=none",
                             mem_addr, mem_we);
                end else begin
                    e = exp_q.pop_front();
                    if (e.we !== mem_we || e.addr !== mem_addr ||
                        (e.we && e.data !== mem_wdata)) begin
                        failures++;
                        $display("FAIL %s request actual=%b/%h/%h expected=%b/%h/%h",
                                 e.tag, mem_we, mem_addr, mem_wdata, e.we, e.addr, e.data);
                    end
                end
                mem_rdata = ram[mem_addr[7:0]];
                if (mem_we) ram[mem_addr[7:0]] = mem_wdata;
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 256; i++) ram[i] = 8'(i) ^ 8'h5A;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1: idle status and blink mirror
        host_read(1'b1, v); check("R1 idle status", {8'h0, v}, 16'h0023);
        check("R13 pointer-independent cfg reset", cfg_text_base, 16'h0000);
        scan_blink = 1'b1;
        host_read(1'b1, v); check("R1 blink bit", {8'h0, v}, 16'h00A3);
        scan_blink = 1'b0;

        // R2/R3: three operands, the last two set the pointer 1234h
        host_write(1'b0, 8'h11, 20);
        host_write(1'b0, 8'h34, 20);
        host_write(1'b0, 8'h12, 20);
        host_write(1'b1, 8'h24, 20);
        // R6: write with increment, hold, decrement
        expect_mem(1'b1, 16'h1234, 8'hAB, "R3");
        host_write(1'b0, 8'hAB, 20); host_write(1'b1, 8'hC0, 20);
        expect_mem(1'b1, 16'h1235, 8'hCD, "R6");
        host_write(1'b0, 8'hCD, 20); host_write(1'b1, 8'hC4, 20);
        expect_mem(1'b1, 16'h1235, 8'hEF, "R6");
        host_write(1'b0, 8'hEF, 20); host_write(1'b1, 8'hC2, 20);
        // R7: reads with hold, increment, decrement
        expect_mem(1'b0, 16'h1234, 8'h00, "R7");
        host_write(1'b1, 8'hC5, 20);
        host_read(1'b0, v); check("R7 read hold", {8'h0, v}, 16'h00AB);
        expect_mem(1'b0, 16'h1234, 8'h00, "R7");
        host_write(1'b1, 8'hC1, 20);
        host_read(1'b0, v); check("R7 read inc", {8'h0, v}, 16'h00AB);
        expect_mem(1'b0, 16'h1235, 8'h00, "R7");
        host_write(1'b1, 8'hC3, 20);
        host_read(1'b0, v); check("R7 read dec", {8'h0, v}, 16'h00EF);

        // R8: bit set with a slow arbiter, status held low while busy
        resp_delay = 30;
        expect_mem(1'b0, 16'h1234, 8'h00, "R8");
        expect_mem(1'b1, 16'h1234, 8'hAF, "R8");
        host_write(1'b1, 8'hFA, 18);
        host_read(1'b1, v); check("R8 busy status", {8'h0, v}, 16'h0020);
        repeat (100) @(negedge clk);
        host_read(1'b1, v); check("R8 done status", {8'h0, v}, 16'h0023);
        resp_delay = 2;
        expect_mem(1'b0, 16'h1234, 8'h00, "R8");
        expect_mem(1'b1, 16'h1234, 8'hAE, "R8");
        host_write(1'b1, 8'hF0, 20);
        expect_mem(1'b0, 16'h1234, 8'h00, "R8");
        host_write(1'b1, 8'hC5, 20);
        host_read(1'b0, v); check("R8 bit clear result", {8'h0, v}, 16'h00AE);

        // R4: cursor and generator base masking
        host_write(1'b0, 8'hFF, 20); host_write(1'b0, 8'hFF, 20); host_write(1'b1, 8'h21, 20);
        check("R4 cursor x", {9'h0, cfg_cur_x}, 16'h007F);
        check("R4 cursor y", {11'h0, cfg_cur_y}, 16'h001F);
        host_write(1'b0, 8'h53, 20); host_write(1'b0, 8'h00, 20); host_write(1'b1, 8'h22, 20);
        check("R4 cg base", {11'h0, cfg_cg_base}, 16'h0013);

        // R5: window words
        host_write(1'b0, 8'h00, 20); host_write(1'b0, 8'h02, 20); host_write(1'b1, 8'h40, 20);
        host_write(1'b0, 8'h1E, 20); host_write(1'b0, 8'h00, 20); host_write(1'b1, 8'h41, 20);
        host_write(1'b0, 8'h00, 20); host_write(1'b0, 8'h08, 20); host_write(1'b1, 8'h42, 20);
        host_write(1'b0, 8'h20, 20); host_write(1'b0, 8'h00, 20); host_write(1'b1, 8'h43, 20);
        check("R5 text base", cfg_text_base, 16'h0200);
        check("R5 text cols", {8'h0, cfg_text_cols}, 16'h001E);
        check("R5 gfx base", cfg_gfx_base, 16'h0800);
        check("R5 gfx cols", {8'h0, cfg_gfx_cols}, 16'h0020);

        // R14: mode fields
        host_write(1'b1, 8'h85, 20); host_write(1'b1, 8'h9E, 20); host_write(1'b1, 8'hA6, 20);
        check("R14 mix", {12'h0, cfg_mix}, 16'h0005);
        check("R14 view", {12'h0, cfg_view}, 16'h000E);
        check("R14 cursor rows", {13'h0, cfg_cur_rows}, 16'h0006);

        // R11: a byte inside the pacing window is dropped
        host_write(1'b0, 8'h40, 20);
        host_write(1'b0, 8'h00, 2);
        host_write(1'b0, 8'h77, 20);
        host_write(1'b1, 8'h24, 20);
        expect_mem(1'b1, 16'h0040, 8'h99, "R11");
        host_write(1'b0, 8'h99, 20); host_write(1'b1, 8'hC4, 20);

        // R9: streaming write
        host_write(1'b0, 8'h50, 20); host_write(1'b0, 8'h00, 20); host_write(1'b1, 8'h24, 20);
        host_write(1'b1, 8'hB0, 20);
        host_read(1'b1, v); check("R9 stream write status", {8'h0, v}, 16'h0028);
        expect_mem(1'b1, 16'h0050, 8'h01, "R9");
        host_write(1'b0, 8'h01, 20);
        expect_mem(1'b1, 16'h0051, 8'h02, "R9");
        host_write(1'b0, 8'h02, 20);
        // R10: foreign opcode rejected, B2h exits
        host_write(1'b1, 8'h24, 20);
        host_read(1'b1, v); check("R10 rejected in stream", {8'h0, v}, 16'h0068);
        host_write(1'b1, 8'hB2, 20);
        host_read(1'b1, v); check("R10 stream exit", {8'h0, v}, 16'h0023);
        expect_mem(1'b0, 16'h0052, 8'h00, "R10");
        host_write(1'b1, 8'hC5, 20);
        host_read(1'b0, v); check("R10 pointer kept", {8'h0, v}, 16'h0008);

        // R9: streaming read
        host_write(1'b0, 8'h60, 20); host_write(1'b0, 8'h00, 20); host_write(1'b1, 8'h24, 20);
        expect_mem(1'b0, 16'h0060, 8'h00, "R9");
        host_write(1'b1, 8'hB1, 20);
        host_read(1'b1, v); check("R9 stream read status", {8'h0, v}, 16'h0024);
        expect_mem(1'b0, 16'h0061, 8'h00, "R9");
        host_read(1'b0, v); check("R9 stream byte 0", {8'h0, v}, 16'h003A);
        repeat (20) @(negedge clk);
        expect_mem(1'b0, 16'h0062, 8'h00, "R9");
        host_read(1'b0, v); check("R9 stream byte 1", {8'h0, v}, 16'h003B);
        repeat (20) @(negedge clk);
        host_write(1'b1, 8'hB2, 20);

        // R12: unknown opcode, missing operand, then recovery
        host_write(1'b1, 8'h30, 20);
        host_read(1'b1, v); check("R12 unknown opcode", {8'h0, v}, 16'h0063);
        host_write(1'b0, 8'h10, 20); host_write(1'b1, 8'h24, 20);
        host_read(1'b1, v); check("R12 short operands", {8'h0, v}, 16'h0063);
        host_write(1'b1, 8'h83, 20);
        host_read(1'b1, v); check("R12 error cleared", {8'h0, v}, 16'h0023);
        check("R12 mix updated", {12'h0, cfg_mix}, 16'h0003);
        expect_mem(1'b0, 16'h0063, 8'h00, "R12");
        host_write(1'b1, 8'hC5, 20);
        host_read(1'b0, v); check("R12 pointer untouched", {8'h0, v}, 16'h0039);

        // R13: reset empties the stage, leaves stream mode, zeroes the pointer
        host_write(1'b0, 8'h05, 20); host_write(1'b0, 8'h06, 20);
        pulse_reset();
        host_write(1'b0, 8'h07, 20); host_write(1'b1, 8'h24, 20);
        host_read(1'b1, v); check("R13 stage emptied", {8'h0, v}, 16'h0063);
        host_write(1'b1, 8'hB0, 20);
        pulse_reset();
        host_read(1'b1, v); check("R13 stream cleared", {8'h0, v}, 16'h0023);
        expect_mem(1'b0, 16'h0000, 8'h00, "R13");
        host_write(1'b1, 8'hC5, 20);
        host_read(1'b0, v); check("R13 pointer zero", {8'h0, v}, 16'h005A);

        repeat (20) @(negedge clk);
        check("R6 all requests seen", 16'(exp_q.size()), 16'h0000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule